// File: doc/BRIEF.md
# LZ4 Block Sequence Parser

This block reads a compressed LZ4 block one byte at a time and breaks it into sequences. Each sequence opens with a token byte. Its upper nibble carries the literal count and its lower nibble carries the base match length. Literal bytes go straight out on a literal stream. For each back-reference the parser issues one match command, holding an offset and a length, on a separate command port. Copying matches, keeping history and handling frame headers or checksums are left to the blocks around it.

No byte count marks the end of the data. Instead, a sequence whose two offset bytes are both zero is the terminator. The parser then raises `done`, issues no command for that sequence and stops taking input. Only a synchronous reset or a one-cycle `start` pulse returns it to waiting for a token.

All three streams use valid/ready. A byte moves when valid and ready are both high at a rising clock edge. A source may not withdraw valid or change data until its byte has been taken. The input is passed through to the literal port with no register in between: while literals are being copied, `in_ready` equals `lit_ready`, so back-pressure on literals stalls the input in the same cycle. While a command waits for `cmd_ready`, its fields stay frozen and no input is accepted.

Top module: `lz4_seq_parser`

## Requirements
- R1: After reset, `done`, `lit_valid` and `cmd_valid` are low and `in_ready` is high, because the parser is waiting for a token byte.
- R2: Bits 7:4 of the token give the literal count and bits 3:0 give the base match length. The literal bytes that follow appear on `lit_data` in the order they were received, and there are exactly as many as the decoded count.
- R3: A nibble of 15 starts a chain of extension bytes. Each byte is added to a 16-bit length, and carries propagate into the upper byte. The first byte not equal to 255 closes the chain and is also added.
- R4: A literal nibble of 15 followed by a single extension byte of 0 produces exactly 15 literals.
- R5: Literal extension bytes are read directly after the token. Match extension bytes are read after both offset bytes.
- R6: `cmd_len` equals the decoded match length plus 4, so it is never below 4.
- R7: The offset is read low byte first and then high byte, and appears unchanged on `cmd_offset`.
- R8: When both offset bytes are zero, `done` rises, no command is issued for that sequence, and `in_ready` stays low while `done` is high.
- R9: A literal nibble of 0 (with no extension) produces no literal output, and the next two input bytes are taken as the offset.
- R10: If `lit_ready` is low while a literal is offered, `in_ready` is low and no byte is lost. A command with `cmd_valid` high and `cmd_ready` low keeps its offset and length until it is accepted.
- R11: `done` remains high until reset or a `start` pulse. After `start`, the parser waits for a token with `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that restarts parsing at a token |
| in_data | input | 8 | Compressed byte |
| in_valid | input | 1 | Compressed byte is present |
| in_ready | output | 1 | Parser takes the byte this cycle |
| lit_data | output | 8 | Literal byte |
| lit_valid | output | 1 | Literal byte is present |
| lit_ready | input | 1 | Consumer takes the literal |
| cmd_offset | output | 16 | Match distance |
| cmd_len | output | 16 | Match length in bytes |
| cmd_valid | output | 1 | Match command is present |
| cmd_ready | input | 1 | Consumer takes the command |
| done | output | 1 | End marker seen |

## Verification
Results fall due at three different times, and each check samples at the time its result is due. A literal appears on `lit_data` in the same cycle its input byte is offered, and `in_ready` follows `lit_ready` in that same cycle. A match command becomes valid one cycle after the edge that accepts its last offset or extension byte. `done` rises one cycle after the edge that accepts a zero high offset byte. The bench drives every input just after a falling edge and samples the outputs one time unit later. It counts a handshake only when valid and ready are both high at that sample, which is the point at which the next rising edge commits it. Literals and commands are therefore compared in handshake order against lists built while encoding the stream, independent of how long stalls last.

// File: rtl/lz4p_pkg.sv
package lz4p_pkg;
  typedef enum logic [2:0] {
    ST_TOKEN,
    ST_LIT_EXT,
    ST_LIT_COPY,
    ST_OFF_LO,
    ST_OFF_HI,
    ST_MATCH_EXT,
    ST_EMIT,
    ST_DONE
  } pstate_t;

  localparam int          BYTE_W    = 8;
  localparam int          NIB_W     = 4;
  localparam logic [3:0]  NIB_ESC   = 4'hF;
  localparam logic [7:0]  EXT_MORE  = 8'hFF;
  localparam int          MIN_MATCH = 4;
endpackage

// File: rtl/lz4p_len_acc.sv
// Length accumulator: loaded from a token nibble, grown by extension bytes,
// optionally counted down one per transferred literal.
module lz4p_len_acc #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [3:0]       nib,
  input  logic             add,
  input  logic [7:0]       ext,
  input  logic             dec,
  output logic [LEN_W-1:0] value
);
  localparam int PAD_NIB = LEN_W - 4;
  localparam int PAD_EXT = LEN_W - 8;

  always_ff @(posedge clk) begin
    if (rst)       value <= '0;
    else if (load) value <= {{PAD_NIB{1'b0}}, nib};
    else if (add)  value <= value + {{PAD_EXT{1'b0}}, ext};
    else if (dec)  value <= value - LEN_W'(1);
  end

  // R2: a literal is never counted off an empty counter
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (rst)
    dec |-> value != '0);
endmodule

// File: rtl/lz4p_off_cap.sv
// Little-endian offset capture with early zero detection on the high byte.
module lz4p_off_cap (
  input  logic        clk,
  input  logic        rst,
  input  logic        cap_lo,
  input  logic        cap_hi,
  input  logic [7:0]  din,
  output logic [15:0] offset,
  output logic        zero_next
);
  logic [7:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (cap_lo) lo_q <= din;
      if (cap_hi) hi_q <= din;
    end
  end

  assign offset    = {hi_q, lo_q};
  assign zero_next = (din == 8'h00) && (lo_q == 8'h00);

  // R7: the low byte is never overwritten while the high byte is taken
  a_r7_lo_first: assert property (@(posedge clk) disable iff (rst)
    cap_hi |-> !cap_lo);
endmodule

// File: rtl/lz4p_ctrl.sv
// Sequence state machine: steers bytes to literal, offset and length paths.
module lz4p_ctrl
  import lz4p_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       lit_ready,
  input  logic       cmd_ready,
  input  logic       lit_last,
  input  logic       off_zero,
  output logic       in_ready,
  output logic       lit_valid,
  output logic       cmd_valid,
  output logic       done,
  output logic       lit_load,
  output logic       lit_add,
  output logic       lit_dec,
  output logic       mat_load,
  output logic       mat_add,
  output logic       off_lo,
  output logic       off_hi
);
  pstate_t state, nxt;
  logic    mat_esc;
  logic    take;

  always_comb begin
    unique case (state)
      ST_TOKEN, ST_LIT_EXT, ST_OFF_LO,
      ST_OFF_HI, ST_MATCH_EXT: in_ready = !start;
      ST_LIT_COPY:             in_ready = lit_ready && !start;
      default:                 in_ready = 1'b0;
    endcase
  end

  assign take      = in_valid && in_ready;
  assign lit_valid = (state == ST_LIT_COPY) && in_valid && !start;
  assign cmd_valid = (state == ST_EMIT) && !start;
  assign done      = (state == ST_DONE);

  always_comb begin
    nxt      = state;
    lit_load = 1'b0;
    lit_add  = 1'b0;
    lit_dec  = 1'b0;
    mat_load = 1'b0;
    mat_add  = 1'b0;
    off_lo   = 1'b0;
    off_hi   = 1'b0;
    unique case (state)
      ST_TOKEN: if (take) begin
        lit_load = 1'b1;
        mat_load = 1'b1;
        if (in_data[7:4] == NIB_ESC)    nxt = ST_LIT_EXT;
        else if (in_data[7:4] == 4'h0)  nxt = ST_OFF_LO;
        else                            nxt = ST_LIT_COPY;
      end
      ST_LIT_EXT: if (take) begin
        lit_add = 1'b1;
        if (in_data != EXT_MORE) nxt = ST_LIT_COPY;
      end
      ST_LIT_COPY: if (take) begin
        lit_dec = 1'b1;
        if (lit_last) nxt = ST_OFF_LO;
      end
      ST_OFF_LO: if (take) begin
        off_lo = 1'b1;
        nxt    = ST_OFF_HI;
      end
      ST_OFF_HI: if (take) begin
        off_hi = 1'b1;
        if (off_zero)     nxt = ST_DONE;
        else if (mat_esc) nxt = ST_MATCH_EXT;
        else              nxt = ST_EMIT;
      end
      ST_MATCH_EXT: if (take) begin
        mat_add = 1'b1;
        if (in_data != EXT_MORE) nxt = ST_EMIT;
      end
      ST_EMIT: if (cmd_valid && cmd_ready) nxt = ST_TOKEN;
      default: nxt = ST_DONE;
    endcase
    if (start) nxt = ST_TOKEN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_TOKEN;
      mat_esc <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_TOKEN && take) mat_esc <= (in_data[3:0] == NIB_ESC);
    end
  end

  // R9: a zero literal nibble goes straight to the offset bytes
  a_r9_skip_literals: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TOKEN && take && in_data[7:4] == 4'h0) |=> state == ST_OFF_LO);
  // R5: match extension bytes only follow the high offset byte
  a_r5_ext_after_offset: assert property (@(posedge clk) disable iff (rst)
    $rose(state == ST_MATCH_EXT) |-> $past(state) == ST_OFF_HI);
endmodule

// File: rtl/lz4_seq_parser.sv
module lz4_seq_parser
  import lz4p_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [7:0]       lit_data,
  output logic             lit_valid,
  input  logic             lit_ready,
  output logic [15:0]      cmd_offset,
  output logic [LEN_W-1:0] cmd_len,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic             done
);
  logic             lit_load, lit_add, lit_dec;
  logic             mat_load, mat_add;
  logic             off_lo, off_hi, off_zero;
  logic [LEN_W-1:0] lit_cnt, mat_cnt;
  logic             lit_last;

  assign lit_last = (lit_cnt == LEN_W'(1));
  assign lit_data = in_data;
  assign cmd_len  = mat_cnt + LEN_W'(MIN_MATCH);

  lz4p_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .in_data(in_data), .in_valid(in_valid),
    .lit_ready(lit_ready), .cmd_ready(cmd_ready),
    .lit_last(lit_last), .off_zero(off_zero),
    .in_ready(in_ready), .lit_valid(lit_valid),
    .cmd_valid(cmd_valid), .done(done),
    .lit_load(lit_load), .lit_add(lit_add), .lit_dec(lit_dec),
    .mat_load(mat_load), .mat_add(mat_add),
    .off_lo(off_lo), .off_hi(off_hi)
  );

  lz4p_len_acc #(.LEN_W(LEN_W)) u_lit_len (
    .clk(clk), .rst(rst),
    .load(lit_load), .nib(in_data[7:4]),
    .add(lit_add), .ext(in_data),
    .dec(lit_dec), .value(lit_cnt)
  );

  lz4p_len_acc #(.LEN_W(LEN_W)) u_mat_len (
    .clk(clk), .rst(rst),
    .load(mat_load), .nib(in_data[3:0]),
    .add(mat_add), .ext(in_data),
    .dec(1'b0), .value(mat_cnt)
  );

  lz4p_off_cap u_off (
    .clk(clk), .rst(rst),
    .cap_lo(off_lo), .cap_hi(off_hi),
    .din(in_data), .offset(cmd_offset), .zero_next(off_zero)
  );

  // R10: a waiting command holds its fields
  a_r10_cmd_hold: assert property (@(posedge clk) disable iff (rst || start)
    (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd_offset) && $stable(cmd_len));
  // R10: a stalled literal stalls the input
  a_r10_lit_stall: assert property (@(posedge clk) disable iff (rst)
    (lit_valid && !lit_ready) |-> !in_ready);
  // R8: end state is quiet
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> !in_ready && !cmd_valid && !lit_valid);
  // R11: done only leaves on start
  a_r11_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
  // R6: commands never carry a length below the minimum
  a_r6_len_floor: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> cmd_len >= LEN_W'(MIN_MATCH));
endmodule

// File: tb/lz4_seq_parser_test.sv
module lz4_seq_parser_test;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_LIMIT  = 40000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  lit_data;
  logic        lit_valid;
  logic        lit_ready = 1'b0;
  logic [15:0] cmd_offset;
  logic [15:0] cmd_len;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0]  strm   [0:8191];
  logic [7:0]  explit [0:8191];
  logic [15:0] expoff [0:255];
  logic [15:0] explen [0:255];
  int slen, nlit, ncmd;

  always #(CLK_PERIOD/2) clk = ~clk;

  lz4_seq_parser uut (
    .clk(clk), .rst(rst), .start(start),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .lit_data(lit_data), .lit_valid(lit_valid), .lit_ready(lit_ready),
    .cmd_offset(cmd_offset), .cmd_len(cmd_len),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nib_of(input int len);
    return (len >= 15) ? 15 : len;
  endfunction

  task automatic push(input logic [7:0] b);
    strm[slen] = b;
    slen++;
  endtask

  task automatic push_ext(input int rem);
    int r = rem;
    while (r >= 255) begin
      push(8'hFF);
      r -= 255;
    end
    push(r[7:0]);
  endtask

  task automatic clear_stream();
    slen = 0; nlit = 0; ncmd = 0;
  endtask

  // one sequence; last=1 writes the zero-offset terminator instead of a match
  task automatic add_seq(input int lits, input int mlen, input int off, input bit last);
    int ln = nib_of(lits);
    int mn = last ? 0 : nib_of(mlen - 4);
    logic [7:0] b;
    push({ln[3:0], mn[3:0]});
    if (lits >= 15) push_ext(lits - 15);
    for (int i = 0; i < lits; i++) begin
      b = 8'($urandom);
      push(b);
      explit[nlit] = b;
      nlit++;
    end
    if (last) begin
      push(8'h00);
      push(8'h00);
    end else begin
      push(off[7:0]);
      push(off[15:8]);
      if (mlen - 4 >= 15) push_ext(mlen - 4 - 15);
      expoff[ncmd] = off[15:0];
      explen[ncmd] = mlen[15:0];
      ncmd++;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    in_valid = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(done == 1'b0, "R11 done cleared by start", done, 0);
    chk(in_ready == 1'b1, "R11 token wait after start", in_ready, 1);
  endtask

  task automatic run(input int vpct, input int rpct, input string name);
    int sp = 0, lp = 0, cp = 0, cyc = 0;
    while (!done && cyc < RUN_LIMIT) begin
      @(negedge clk);
      in_valid  = (sp < slen) && (($urandom % 100) < vpct);
      in_data   = in_valid ? strm[sp] : 8'($urandom);
      lit_ready = ($urandom % 100) < rpct;
      cmd_ready = ($urandom % 100) < rpct;
      #1;
      if (lit_valid && !lit_ready)
        chk(in_ready == 1'b0, {"R10 stall ", name}, in_ready, 0);
      if (lit_valid && lit_ready) begin
        chk(lp < nlit && lit_data == explit[(lp < nlit) ? lp : 0],
            {"R2 literal ", name}, lit_data, (lp < nlit) ? explit[lp] : -1);
        lp++;
      end
      if (cmd_valid && cmd_ready) begin
        if (cp < ncmd) begin
          chk(cmd_offset == expoff[cp], {"R7 offset ", name}, cmd_offset, expoff[cp]);
          chk(cmd_len == explen[cp], {"R6 R3 length ", name}, cmd_len, explen[cp]);
        end else begin
          chk(1'b0, {"R8 extra command ", name}, cp, ncmd);
        end
        cp++;
      end
      if (in_valid && in_ready) sp++;
      cyc++;
    end
    if (cyc >= RUN_LIMIT) chk(1'b0, {"watchdog ", name}, cyc, RUN_LIMIT);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(sp == slen, {"R8 bytes consumed ", name}, sp, slen);
    chk(lp == nlit, {"R2 R4 R9 literal count ", name}, lp, nlit);
    chk(cp == ncmd, {"R8 command count ", name}, cp, ncmd);
    chk(done == 1'b1, {"R8 done ", name}, done, 1);
    chk(in_ready == 1'b0, {"R8 input closed ", name}, in_ready, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'h11;
      cmd_ready = 1'b1;
      #1;
      chk(done == 1'b1 && cmd_valid == 1'b0, {"R11 done holds ", name}, done, 1);
    end
    in_valid = 1'b0;
  endtask

  task automatic random_stream(input int nseq);
    int l, m, o;
    clear_stream();
    for (int s = 0; s < nseq; s++) begin
      l = (($urandom % 10) == 0) ? int'($urandom % 600) : int'($urandom % 21);
      m = (($urandom % 10) == 0) ? 4 + int'($urandom % 700) : 4 + int'($urandom % 27);
      o = 1 + int'($urandom % 65535);
      add_seq(l, m, o, 1'b0);
    end
    add_seq(int'($urandom % 21), 0, 0, 1'b1);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(done == 1'b0, "R1 done low", done, 0);
    chk(in_ready == 1'b1, "R1 ready for token", in_ready, 1);
    chk(lit_valid == 1'b0 && cmd_valid == 1'b0, "R1 outputs idle", lit_valid, 0);

    // R9: zero literal count goes straight to offset
    clear_stream();
    add_seq(0, 4, 1, 1'b0);
    add_seq(3, 5, 16'h0302, 1'b0);
    add_seq(5, 0, 0, 1'b1);
    run(100, 100, "R9 zero-literal");

    // R4 R5: nibble 15 with a zero extension byte on both lengths
    pulse_start();
    clear_stream();
    add_seq(15, 19, 16'h0102, 1'b0);
    add_seq(15, 0, 0, 1'b1);
    run(100, 100, "R4 exact fifteen");

    // R3: long chains carrying into the upper byte
    pulse_start();
    clear_stream();
    add_seq(300, 4 + 15 + 255 + 255 + 10, 16'h8001, 1'b0);
    add_seq(270, 4 + 15 + 255, 16'hFFFF, 1'b0);
    add_seq(0, 0, 0, 1'b1);
    run(90, 90, "R3 carry");

    // R10: heavy back-pressure on both outputs
    pulse_start();
    random_stream(30);
    run(70, 20, "R10 backpressure");

    pulse_start();
    random_stream(40);
    run(60, 70, "R2 random mix");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule